// File: doc/BRIEF.md
# Sequence-Unlocked Bank Select Register

This block manages bank switching for a memory card on a host bus with a 20-bit address space and an 8-bit data bus. The host space is split by address bit 19. The upper half always reaches the highest 512K block of flash. The lower half reaches one 512K block of a larger card map, and an 8-bit bank register chooses that block. The register value drives eight extended address lines. A chip-enable decoder uses those lines together with host bit 19 to select the RAM device or the flash device.

The bank register shares the topmost host address with the flash, so it cannot be loaded by a single write. It loads only after an unlock run of back-to-back writes to that address. Three completed writes arm the run, and the data of the fourth write is captured. Once the run is armed, each further write to that address is captured again. Any other access breaks the run, and the count starts again from zero. Writes to the topmost address still reach the flash as ordinary bus cycles.

The bus strobes are sampled into the block clock domain. A write counts when its write-enable pulse ends while the card is enabled. Each capture toggles an indicator output. Software must make no assumption about the bank value after power-up; it must run only from the upper half of the host space.

Top module: `bank_window_ctrl`

## Requirements
- R1: The first three completed writes to address 0xFFFFF do not change the bank register. The data of the fourth consecutive completed write to that address is loaded into the bank register.
- R2: A completed write to any address other than 0xFFFFF clears the write run. The next load again needs four consecutive writes to 0xFFFFF.
- R3: A read access clears the write run, whatever its address. A read access is card enable low with output enable low.
- R4: While the run is armed, every further completed write to 0xFFFFF loads its data, so the bank register holds the last value written.
- R5: With host address bit 19 high, ext_addr is 0xFF. In that state, with card enable low, flash_ce_n is low and ram_ce_n is high. This includes the writes of the unlock run.
- R6: With host address bit 19 low, ext_addr equals the bank register, with bank bit 0 on ext_addr[0]. With card enable low, bank bit 7 set gives flash_ce_n low and ram_ce_n high. Bank bit 7 clear gives ram_ce_n low and flash_ce_n high.
- R7: With card enable high, both ram_ce_n and flash_ce_n are high.
- R8: A synchronous reset (rst_n low at a rising clock edge) clears the bank register to 0x00, clears latch_toggle to 0 and clears the write run.
- R9: latch_toggle inverts once for every load of the bank register and holds its value otherwise.
- R10: Write-enable pulses made while card enable is high are not counted and load nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 20 | Host address bus |
| host_data | input | 8 | Host write data bus |
| host_ce_n | input | 1 | Card enable, active low |
| host_oe_n | input | 1 | Output (read) enable, active low |
| host_we_n | input | 1 | Write enable, active low |
| ext_addr | output | 8 | Extended address lines for the memory devices (card address bits 26..19) |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| latch_toggle | output | 1 | Inverts on every bank register load |

## Verification
The window decode is driven from a table. Each row loads a bank value and then probes with a chosen level of host bit 19 and of card enable. The rows cover both RAM ends, the flash block range, the 0x7F/0x80 boundary where bank bit 7 flips the device, the forced all-ones value of the upper half, and the idle case with the card not enabled. Directed runs then show where the unlock rules give way. One run stops at three writes, which tells arming apart from loading. Other runs break the sequence with a write elsewhere or with a read, which tells a real restart from a count that only pauses. Further runs continue past the fourth write, make write pulses with the card not enabled, and reset mid-run. In each case latch_toggle is checked to show that the number of loads matches the number of captures.

// File: rtl/bank_pkg.sv
`timescale 1ns/1ps
// bank_pkg: shared widths and defaults for the bank window controller.
// Assumes a byte-wide host bus; all users take their widths from here.
package bank_pkg;
    localparam int HOST_ADDR_W = 20;
    localparam int HOST_DATA_W = 8;
    localparam int UNLOCK_WRITES = 3;
endpackage

// File: rtl/bank_seq_detect.sv
`timescale 1ns/1ps
// bank_seq_detect: samples the host strobes and counts completed writes
// to the topmost address. Once UNLOCK_W writes have been counted, each
// further write to that address raises load_pulse for one cycle.
// Assumes the host holds address and data stable around the rising edge
// of the write enable. Any read, or a write to another address, clears the run.
module bank_seq_detect #(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 8,
    parameter int UNLOCK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    output logic              load_pulse,
    output logic [DATA_W-1:0] load_data
);
    localparam int CNT_W = $clog2(UNLOCK_W + 1);
    localparam logic [CNT_W-1:0] ARMED_VAL = CNT_W'(UNLOCK_W);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              ce_n_s, oe_n_s, we_n_s, we_n_p;
    logic [CNT_W-1:0]  run_cnt;

    logic we_release, at_top, rd_access, wr_top, wr_other, run_clear, armed;

    // Sample the bus into the clock domain, keep the previous write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_s <= '0;
            data_s <= '0;
            ce_n_s <= 1'b1;
            oe_n_s <= 1'b1;
            we_n_s <= 1'b1;
            we_n_p <= 1'b1;
        end else begin
            addr_s <= bus_addr;
            data_s <= bus_data;
            ce_n_s <= bus_ce_n;
            oe_n_s <= bus_oe_n;
            we_n_s <= bus_we_n;
            we_n_p <= we_n_s;
        end
    end

    // Classify the sampled bus activity of this cycle.
    always_comb begin
        we_release = !we_n_p && we_n_s && !ce_n_s;
        at_top     = (addr_s == TOP_ADDR);
        rd_access  = !ce_n_s && !oe_n_s;
        wr_top     = we_release && at_top && !rd_access;
        wr_other   = we_release && !at_top;
        run_clear  = rd_access || wr_other;
        armed      = (run_cnt == ARMED_VAL);
    end

    // Run counter: clear on a foreign access, step on a top write, saturate when armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (run_clear) begin
            run_cnt <= '0;
        end else if (wr_top && !armed) begin
            run_cnt <= run_cnt + CNT_W'(1);
        end
    end

    assign load_pulse = wr_top && armed;
    assign load_data  = data_s;

    // R2 / R3: a foreign access restarts the run.
    p_run_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_clear |=> (run_cnt == '0));

    // R1: each top write before arming advances the count by one.
    p_run_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_top && !armed && !run_clear) |=> (run_cnt == $past(run_cnt) + CNT_W'(1)));

    // R4: once armed, further top writes keep the run armed.
    p_stay_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_top && armed) |=> (run_cnt == ARMED_VAL));
endmodule

// File: rtl/bank_hold_reg.sv
`timescale 1ns/1ps
// bank_hold_reg: the bank register and the load indicator.
// Loads din on a one-cycle load strobe and inverts the indicator each time.
// Assumes load is a single-cycle pulse from the sequence detector.
module bank_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] bank,
    output logic              load_flag
);
    // Capture the bank value and flip the indicator on every load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank      <= '0;
            load_flag <= 1'b0;
        end else if (load) begin
            bank      <= din;
            load_flag <= !load_flag;
        end
    end

    // R1 / R4: a load stores the presented data.
    p_load_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bank == $past(din)));

    // R1: without a load the register does not move.
    p_hold_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank));

    // R9: the indicator changes exactly when a load happens.
    p_flag_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (load_flag != $past(load_flag)));
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(load_flag));
endmodule

// File: rtl/bank_window_decode.sv
`timescale 1ns/1ps
// bank_window_decode: forms the extended address lines and device enables.
// Upper host half forces all ones (top flash block); lower half shows the
// bank value. The top extended bit picks flash over RAM. Purely combinational.
module bank_window_decode #(
    parameter int DATA_W = 8
) (
    input  logic              host_hi,
    input  logic              host_ce_n,
    input  logic [DATA_W-1:0] bank,
    output logic [DATA_W-1:0] ext_addr,
    output logic              ram_ce_n,
    output logic              flash_ce_n
);
    logic dev_hi;

    // Window mux and device select.
    always_comb begin
        ext_addr   = host_hi ? '1 : bank;
        dev_hi     = ext_addr[DATA_W-1];
        flash_ce_n = host_ce_n || !(host_hi || dev_hi);
        ram_ce_n   = host_ce_n || host_hi || dev_hi;
    end
endmodule

// File: rtl/bank_window_ctrl.sv
`timescale 1ns/1ps
// bank_window_ctrl: top of the sequence-unlocked bank select block.
// Joins the write-run detector, the bank register and the window decode.
// Assumes a synchronous clock faster than the host strobes, so each
// strobe level is seen for at least two clock cycles.
module bank_window_ctrl #(
    parameter int ADDR_W   = bank_pkg::HOST_ADDR_W,
    parameter int DATA_W   = bank_pkg::HOST_DATA_W,
    parameter int UNLOCK_W = bank_pkg::UNLOCK_WRITES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_ce_n,
    input  logic              host_oe_n,
    input  logic              host_we_n,
    output logic [DATA_W-1:0] ext_addr,
    output logic              ram_ce_n,
    output logic              flash_ce_n,
    output logic              latch_toggle
);
    logic              load_pulse;
    logic [DATA_W-1:0] load_data;
    logic [DATA_W-1:0] bank_val;

    bank_seq_detect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLOCK_W(UNLOCK_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (host_addr),
        .bus_data   (host_data),
        .bus_ce_n   (host_ce_n),
        .bus_oe_n   (host_oe_n),
        .bus_we_n   (host_we_n),
        .load_pulse (load_pulse),
        .load_data  (load_data)
    );

    bank_hold_reg #(.DATA_W(DATA_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_pulse),
        .din       (load_data),
        .bank      (bank_val),
        .load_flag (latch_toggle)
    );

    bank_window_decode #(.DATA_W(DATA_W)) u_dec (
        .host_hi    (host_addr[ADDR_W-1]),
        .host_ce_n  (host_ce_n),
        .bank       (bank_val),
        .ext_addr   (ext_addr),
        .ram_ce_n   (ram_ce_n),
        .flash_ce_n (flash_ce_n)
    );

    // R5: the upper host half always reaches flash with all-ones lines.
    p_upper_flash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ce_n && host_addr[ADDR_W-1]) |-> (!flash_ce_n && ram_ce_n && (ext_addr == '1)));

    // R6: never both devices enabled at once.
    p_one_device_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!ram_ce_n, !flash_ce_n}));

    // R7: no device enabled while the card is idle.
    p_idle_card_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_ce_n |-> (ram_ce_n && flash_ce_n));
endmodule

// File: tb/bank_window_ctrl_bench.sv
`timescale 1ns/1ps
// bank_window_ctrl_bench: table-driven window checks plus directed unlock tests.
module bank_window_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] host_addr = '0;
    logic [7:0]  host_data = '0;
    logic        host_ce_n = 1'b1;
    logic        host_oe_n = 1'b1;
    logic        host_we_n = 1'b1;
    logic [7:0]  ext_addr;
    logic        ram_ce_n, flash_ce_n, latch_toggle;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bank_window_ctrl u_bank_window_ctrl (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_data(host_data),
        .host_ce_n(host_ce_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
        .ext_addr(ext_addr), .ram_ce_n(ram_ce_n), .flash_ce_n(flash_ce_n),
        .latch_toggle(latch_toggle)
    );

    typedef struct packed {
        logic [7:0] bank;
        logic       a19;
        logic       ce_n;
        logic [7:0] ext;
        logic       ram_n;
        logic       flash_n;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
        '{8'h03, 1'b0, 1'b0, 8'h03, 1'b0, 1'b1},
        '{8'hF8, 1'b0, 1'b0, 8'hF8, 1'b1, 1'b0},
        '{8'hFF, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0},
        '{8'h7F, 1'b0, 1'b0, 8'h7F, 1'b0, 1'b1},
        '{8'h80, 1'b0, 1'b0, 8'h80, 1'b1, 1'b0},
        '{8'h03, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0},
        '{8'h03, 1'b0, 1'b1, 8'h03, 1'b1, 1'b1},
        '{8'hF8, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One host write cycle; optionally check the enables mid-write (R5).
    task automatic host_write(input logic [19:0] a, input logic [7:0] d,
                              input logic ce_n, input bit chk_flash);
        wait_cycles(1);
        host_addr = a; host_data = d; host_ce_n = ce_n;
        wait_cycles(2);
        host_we_n = 1'b0;
        wait_cycles(3);
        if (chk_flash) begin
            @(negedge clk);
            check("R5 flash_ce_n during top write", {7'b0, flash_ce_n}, 8'h00);
            check("R5 ram_ce_n during top write", {7'b0, ram_ce_n}, 8'h01);
            #1;
        end
        host_we_n = 1'b1;
        wait_cycles(2);
        host_ce_n = 1'b1;
        wait_cycles(3);
    endtask

    task automatic host_read(input logic [19:0] a);
        wait_cycles(1);
        host_addr = a; host_ce_n = 1'b0;
        wait_cycles(1);
        host_oe_n = 1'b0;
        wait_cycles(3);
        host_oe_n = 1'b1;
        wait_cycles(1);
        host_ce_n = 1'b1;
        wait_cycles(3);
    endtask

    task automatic top_writes(input int n, input logic [7:0] d);
        for (int i = 0; i < n; i++) host_write(20'hFFFFF, d, 1'b0, 1'b0);
    endtask

    // Observe the bank through ext_addr with A19 low and the card idle.
    task automatic probe_bank(input string tag, input logic [7:0] exp);
        wait_cycles(1);
        host_addr = 20'h00000; host_ce_n = 1'b1;
        wait_cycles(2);
        @(negedge clk);
        check(tag, ext_addr, exp);
    endtask

    task automatic do_reset();
        wait_cycles(1);
        rst_n = 1'b0;
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(2);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic exp_tog;
        wait_cycles(5);
        rst_n = 1'b1;
        wait_cycles(2);

        // R8: state after reset; R7 idle enables.
        probe_bank("R8 bank after reset", 8'h00);
        check("R8 latch_toggle after reset", {7'b0, latch_toggle}, 8'h00);
        check("R7 ram_ce_n idle", {7'b0, ram_ce_n}, 8'h01);
        check("R7 flash_ce_n idle", {7'b0, flash_ce_n}, 8'h01);

        // R6 / R5 / R7: table walk over bank values and window probes.
        for (int v = 0; v < NVEC; v++) begin
            top_writes(4, VEC[v].bank);
            wait_cycles(1);
            host_addr = {VEC[v].a19, 19'h0};
            host_ce_n = VEC[v].ce_n;
            wait_cycles(2);
            @(negedge clk);
            check($sformatf("R6 table %0d ext_addr", v), ext_addr, VEC[v].ext);
            check($sformatf("R6 table %0d ram_ce_n", v), {7'b0, ram_ce_n}, {7'b0, VEC[v].ram_n});
            check($sformatf("R6 table %0d flash_ce_n", v), {7'b0, flash_ce_n}, {7'b0, VEC[v].flash_n});
            #1;
            host_ce_n = 1'b1;
        end

        // R1: three writes arm only, the fourth loads.
        do_reset();
        top_writes(3, 8'h5A);
        probe_bank("R1 three writes do not load", 8'h00);
        top_writes(1, 8'h5A);
        probe_bank("R1 fourth write loads", 8'h5A);

        // R2: a write elsewhere restarts the run.
        do_reset();
        top_writes(2, 8'h11);
        host_write(20'h12345, 8'h22, 1'b0, 1'b0);
        top_writes(2, 8'h33);
        probe_bank("R2 run broken by other write", 8'h00);
        top_writes(2, 8'h44);
        probe_bank("R2 four after restart loads", 8'h44);

        // R3: a read at the top address also restarts the run.
        do_reset();
        top_writes(3, 8'h55);
        host_read(20'hFFFFF);
        top_writes(1, 8'h66);
        probe_bank("R3 run broken by read", 8'h00);
        top_writes(3, 8'h67);
        probe_bank("R3 reload after read", 8'h67);

        // R4 / R9: further writes keep loading; the indicator flips each time.
        do_reset();
        exp_tog = 1'b0;
        top_writes(4, 8'h01);
        exp_tog = ~exp_tog;
        check("R9 toggle after first load", {7'b0, latch_toggle}, {7'b0, exp_tog});
        top_writes(1, 8'hC3);
        exp_tog = ~exp_tog;
        probe_bank("R4 fifth write loads", 8'hC3);
        check("R9 toggle after second load", {7'b0, latch_toggle}, {7'b0, exp_tog});
        top_writes(1, 8'h3C);
        exp_tog = ~exp_tog;
        probe_bank("R4 last value held", 8'h3C);
        check("R9 toggle after third load", {7'b0, latch_toggle}, {7'b0, exp_tog});

        // R5: the enables during an unlock write, and the upper half with a RAM bank.
        host_write(20'hFFFFF, 8'h02, 1'b0, 1'b1);
        wait_cycles(1);
        host_addr = 20'h80000; host_ce_n = 1'b0;
        wait_cycles(2);
        @(negedge clk);
        check("R5 ext_addr upper half", ext_addr, 8'hFF);
        #1;
        host_ce_n = 1'b1;

        // R10: write pulses with the card idle are ignored.
        do_reset();
        for (int i = 0; i < 5; i++) host_write(20'hFFFFF, 8'h99, 1'b1, 1'b0);
        probe_bank("R10 idle-card writes ignored", 8'h00);
        check("R10 no toggle on idle writes", {7'b0, latch_toggle}, 8'h00);

        // R8: reset mid-run clears the run.
        top_writes(3, 8'hAB);
        do_reset();
        top_writes(1, 8'hAB);
        probe_bank("R8 run cleared by reset", 8'h00);
        check("R8 toggle cleared by reset", {7'b0, latch_toggle}, 8'h00);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule